// File: doc/BRIEF.md
# Audio Serial Port Control and Interrupt Registers

This block is the software-facing register file of a serial audio port. A simple word-addressed register bus writes commands and configuration, reads status, and moves single audio words between software and the transmit and receive datapaths. The datapaths report back through single-cycle event pulses: a received word is ready, a transmit word has been taken, or a receive overrun or transmit underrun happened on a given time slot. Each of those error events is kept as a sticky summary flag plus a per-slot flag.

The receiver, transmitter and clock generator are switched on and off by one-shot command bits in a write-only control word rather than by level bits. Error flags stay set until software writes a one to the matching bit of a clear register. A separate set register can force them for testing. An interrupt mask is built up and torn down through dedicated enable and disable registers, and one level-sensitive interrupt line reports any ready or error condition left unmasked. A software reset command returns the whole block to its power-up state in one cycle.

Top module: `aud_port_regs`

## Requirements
- R1: After reset, the receiver, transmitter and clock enables are low, the interrupt is low, the mask reads 0, the mode word reads 0, and status (word 0x08) reads 0x0000_0020, meaning the transmit holding register is empty.
- R2: In a write to control (0x00), bit0 turns the receiver on and bit1 turns it off, bit2 turns the clock on and bit3 turns it off, and bit4 turns the transmitter on and bit5 turns it off. If both bits of a pair are set in the same write, the disable takes effect. Status bit0 mirrors the receiver enable and status bit4 mirrors the transmitter enable. Control reads back 0.
- R3: An overrun pulse sets status bit2 and bit 8+ch. An underrun pulse sets status bit6 and bit 20+ch. A channel index of NUM_CH or more sets only the summary bit. The flags stay set until they are cleared.
- R4: Writing a 1 to a bit of the clear register (0x0C) clears the matching sticky bit (2, 6, 15:8, 27:20). An error event in the same cycle takes priority over the clear.
- R5: Writing a 1 to a bit of the set register (0x10) forces the matching sticky bit to 1. Writing 0 leaves it unchanged.
- R6: Writing to interrupt enable (0x14) ORs its data into the mask, and writing to interrupt disable (0x18) clears the written bits. The mask reads back at 0x1C. Only bits 1, 2, 5 and 6 can be set.
- R7: The interrupt line is high exactly when status ANDed with the mask is nonzero.
- R8: A receive push loads the receive holding word and sets status bit1. A read of 0x20 returns the word and clears bit1. A push in the same cycle as that read leaves bit1 set.
- R9: A write to 0x24 loads the transmit word output and clears status bit5. A transmit pop sets bit5 again. A write and a pop in the same cycle leave bit5 clear.
- R10: A control write with bit7 set returns all enables, flags, the mask, the mode word and both holding registers to their reset values in one cycle. It overrides the other bits of that write and any events in that cycle.
- R11: The mode word (0x04) is readable and writable through MODE_WMASK and drives mode_cfg. Word 0x28 reads VERSION_ID. All other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (consumes the receive word at 0x20) |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| rx_push | input | 1 | Receive datapath delivers a word |
| rx_word | input | 32 | Word delivered with rx_push |
| rx_ovr_evt | input | 1 | Receive overrun pulse |
| rx_ovr_ch | input | CH_W | Slot index of the overrun |
| tx_pop | input | 1 | Transmit datapath takes the held word |
| tx_und_evt | input | 1 | Transmit underrun pulse |
| tx_und_ch | input | CH_W | Slot index of the underrun |
| tx_word | output | 32 | Held transmit word |
| mode_cfg | output | 32 | Mode word for the datapaths |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| clk_en | output | 1 | Clock generator enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with NUM_CH = 6 while the channel index stays 3 bits wide. This makes slot indices 6 and 7 legal input values that have no per-slot flag, so the summary-only path of an out-of-range event is reachable. It also makes the upper two bits of each per-slot field constants that clear and set writes must not disturb. MODE_WMASK keeps its all-ones default and VERSION_ID is overridden to a distinct value, so the version read cannot pass by coincidence.

// File: rtl/aud_regs_pkg.sv
package aud_regs_pkg;
   // word indices (byte offset / 4)
   localparam int W_CTRL = 0;
   localparam int W_MODE = 1;
   localparam int W_STAT = 2;
   localparam int W_SCLR = 3;
   localparam int W_SSET = 4;
   localparam int W_IEN  = 5;
   localparam int W_IDIS = 6;
   localparam int W_IMSK = 7;
   localparam int W_RHR  = 8;
   localparam int W_THR  = 9;
   localparam int W_VER  = 10;

   // control command bits
   localparam int CB_RX_ON  = 0;
   localparam int CB_RX_OFF = 1;
   localparam int CB_CK_ON  = 2;
   localparam int CB_CK_OFF = 3;
   localparam int CB_TX_ON  = 4;
   localparam int CB_TX_OFF = 5;
   localparam int CB_RESET  = 7;

   // status bits
   localparam int SB_RX_ON  = 0;
   localparam int SB_RX_RDY = 1;
   localparam int SB_RX_OVR = 2;
   localparam int SB_TX_ON  = 4;
   localparam int SB_TX_RDY = 5;
   localparam int SB_TX_UND = 6;
   localparam int SB_OVR_CH = 8;
   localparam int SB_UND_CH = 20;

   localparam int MAX_CH = 8;
   localparam logic [31:0] IRQ_SRC = 32'h0000_0066;

   typedef struct packed {
      logic ctrl;
      logic mode;
      logic sclr;
      logic sset;
      logic ien;
      logic idis;
      logic thr;
   } wr_sel_t;
endpackage

// File: rtl/aud_cmd_enable.sv
module aud_cmd_enable #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic [N-1:0] on,
   input  logic [N-1:0] off,
   output logic [N-1:0] en_q
);
   for (genvar i = 0; i < N; i++) begin : g_en
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      en_q[i] <= 1'b0;
         else if (srst)   en_q[i] <= 1'b0;
         else if (off[i]) en_q[i] <= 1'b0;
         else if (on[i])  en_q[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/aud_err_flags.sv
module aud_err_flags
   import aud_regs_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CH_W   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            srst,
   input  logic [31:0]     clr,
   input  logic [31:0]     set,
   input  logic            ovr_evt,
   input  logic [CH_W-1:0] ovr_ch,
   input  logic            und_evt,
   input  logic [CH_W-1:0] und_ch,
   output logic [31:0]     flags
);
   logic              ovr_q, und_q;
   logic [NUM_CH-1:0] ovr_ch_q, und_ch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         und_q <= 1'b0;
      end else if (srst) begin
         ovr_q <= 1'b0;
         und_q <= 1'b0;
      end else begin
         ovr_q <= (ovr_q & ~clr[SB_RX_OVR]) | set[SB_RX_OVR] | ovr_evt;
         und_q <= (und_q & ~clr[SB_TX_UND]) | set[SB_TX_UND] | und_evt;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic ovr_hit, und_hit;
      assign ovr_hit = ovr_evt && (ovr_ch == CH_W'(c));
      assign und_hit = und_evt && (und_ch == CH_W'(c));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ovr_ch_q[c] <= 1'b0;
            und_ch_q[c] <= 1'b0;
         end else if (srst) begin
            ovr_ch_q[c] <= 1'b0;
            und_ch_q[c] <= 1'b0;
         end else begin
            ovr_ch_q[c] <= (ovr_ch_q[c] & ~clr[SB_OVR_CH+c]) | set[SB_OVR_CH+c] | ovr_hit;
            und_ch_q[c] <= (und_ch_q[c] & ~clr[SB_UND_CH+c]) | set[SB_UND_CH+c] | und_hit;
         end
      end
   end

   always_comb begin
      flags                      = '0;
      flags[SB_RX_OVR]           = ovr_q;
      flags[SB_TX_UND]           = und_q;
      flags[SB_OVR_CH +: NUM_CH] = ovr_ch_q;
      flags[SB_UND_CH +: NUM_CH] = und_ch_q;
   end
endmodule

// File: rtl/aud_irq_ctl.sv
module aud_irq_ctl
   import aud_regs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        srst,
   input  logic        ien_wr,
   input  logic        idis_wr,
   input  logic [31:0] wdata,
   input  logic [31:0] status,
   output logic [31:0] mask_q,
   output logic        irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (srst)    mask_q <= '0;
      else if (ien_wr)  mask_q <= mask_q | (wdata & IRQ_SRC);
      else if (idis_wr) mask_q <= mask_q & ~wdata;
   end

   assign irq = |(status & mask_q);
endmodule

// File: rtl/aud_port_regs.sv
module aud_port_regs
   import aud_regs_pkg::*;
#(
   parameter int          NUM_CH     = 8,
   parameter int          ADDR_W     = 6,
   parameter logic [31:0] VERSION_ID = 32'h0000_0118,
   parameter logic [31:0] MODE_WMASK = 32'hFFFF_FFFF,
   localparam int         CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              rx_push,
   input  logic [31:0]       rx_word,
   input  logic              rx_ovr_evt,
   input  logic [CH_W-1:0]   rx_ovr_ch,
   input  logic              tx_pop,
   input  logic              tx_und_evt,
   input  logic [CH_W-1:0]   tx_und_ch,
   output logic [31:0]       tx_word,
   output logic [31:0]       mode_cfg,
   output logic              rx_en,
   output logic              tx_en,
   output logic              clk_en,
   output logic              irq
);
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("aud_port_regs: NUM_CH must be 1..8");
   end
   if (ADDR_W < 6) begin : g_bad_aw
      $error("aud_port_regs: ADDR_W must be at least 6");
   end

   localparam int WI_W = ADDR_W - 2;

   logic [WI_W-1:0] widx;
   wr_sel_t         ws;
   logic            srst, rhr_rd;
   logic [31:0]     mode_q, rx_hold_q, tx_hold_q;
   logic            rxrdy_q, thr_full_q;
   logic [2:0]      cmd_on, cmd_off, en_q;
   logic [31:0]     sclr_v, sset_v, err_flags, status_w, irq_mask;

   assign widx    = bus_addr[ADDR_W-1:2];
   assign ws.ctrl = bus_wr && (widx == WI_W'(W_CTRL));
   assign ws.mode = bus_wr && (widx == WI_W'(W_MODE));
   assign ws.sclr = bus_wr && (widx == WI_W'(W_SCLR));
   assign ws.sset = bus_wr && (widx == WI_W'(W_SSET));
   assign ws.ien  = bus_wr && (widx == WI_W'(W_IEN));
   assign ws.idis = bus_wr && (widx == WI_W'(W_IDIS));
   assign ws.thr  = bus_wr && (widx == WI_W'(W_THR));
   assign rhr_rd  = bus_rd && (widx == WI_W'(W_RHR));
   assign srst    = ws.ctrl && bus_wdata[CB_RESET];

   // enable index: 0 receiver, 1 clock, 2 transmitter
   assign cmd_on  = {3{ws.ctrl}} & {bus_wdata[CB_TX_ON],  bus_wdata[CB_CK_ON],  bus_wdata[CB_RX_ON]};
   assign cmd_off = {3{ws.ctrl}} & {bus_wdata[CB_TX_OFF], bus_wdata[CB_CK_OFF], bus_wdata[CB_RX_OFF]};

   aud_cmd_enable #(.N(3)) u_en (
      .clk  (clk),
      .rst_n(rst_n),
      .srst (srst),
      .on   (cmd_on),
      .off  (cmd_off),
      .en_q (en_q)
   );
   assign rx_en  = en_q[0];
   assign clk_en = en_q[1];
   assign tx_en  = en_q[2];

   assign sclr_v = ws.sclr ? bus_wdata : '0;
   assign sset_v = ws.sset ? bus_wdata : '0;

   aud_err_flags #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst   (srst),
      .clr    (sclr_v),
      .set    (sset_v),
      .ovr_evt(rx_ovr_evt),
      .ovr_ch (rx_ovr_ch),
      .und_evt(tx_und_evt),
      .und_ch (tx_und_ch),
      .flags  (err_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= '0;
         rx_hold_q  <= '0;
         rxrdy_q    <= 1'b0;
         tx_hold_q  <= '0;
         thr_full_q <= 1'b0;
      end else if (srst) begin
         mode_q     <= '0;
         rx_hold_q  <= '0;
         rxrdy_q    <= 1'b0;
         tx_hold_q  <= '0;
         thr_full_q <= 1'b0;
      end else begin
         if (ws.mode) mode_q <= (mode_q & ~MODE_WMASK) | (bus_wdata & MODE_WMASK);
         if (rx_push) begin
            rx_hold_q <= rx_word;
            rxrdy_q   <= 1'b1;
         end else if (rhr_rd) begin
            rxrdy_q   <= 1'b0;
         end
         if (ws.thr) begin
            tx_hold_q  <= bus_wdata;
            thr_full_q <= 1'b1;
         end else if (tx_pop) begin
            thr_full_q <= 1'b0;
         end
      end
   end

   always_comb begin
      status_w            = err_flags;
      status_w[SB_RX_ON]  = rx_en;
      status_w[SB_RX_RDY] = rxrdy_q;
      status_w[SB_TX_ON]  = tx_en;
      status_w[SB_TX_RDY] = ~thr_full_q;
   end

   aud_irq_ctl u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst   (srst),
      .ien_wr (ws.ien),
      .idis_wr(ws.idis),
      .wdata  (bus_wdata),
      .status (status_w),
      .mask_q (irq_mask),
      .irq    (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if      (widx == WI_W'(W_MODE)) bus_rdata = mode_q;
      else if (widx == WI_W'(W_STAT)) bus_rdata = status_w;
      else if (widx == WI_W'(W_IMSK)) bus_rdata = irq_mask;
      else if (widx == WI_W'(W_RHR))  bus_rdata = rx_hold_q;
      else if (widx == WI_W'(W_VER))  bus_rdata = VERSION_ID;
   end

   assign tx_word  = tx_hold_q;
   assign mode_cfg = mode_q;
endmodule

// File: rtl/aud_port_regs_chk.sv
module aud_port_regs_chk
   import aud_regs_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              rx_push,
   input logic              rx_ovr_evt,
   input logic              rx_en,
   input logic              tx_en,
   input logic              clk_en,
   input logic              irq,
   input logic [31:0]       stat_vec,
   input logic [31:0]       mask_q
);
   localparam int WI_W = ADDR_W - 2;
   logic ctl_w, srst_c, idis_w, rhr_r;
   assign ctl_w  = bus_wr && (bus_addr[ADDR_W-1:2] == WI_W'(W_CTRL));
   assign srst_c = ctl_w && bus_wdata[CB_RESET];
   assign idis_w = bus_wr && (bus_addr[ADDR_W-1:2] == WI_W'(W_IDIS));
   assign rhr_r  = bus_rd && (bus_addr[ADDR_W-1:2] == WI_W'(W_RHR));

   AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      srst_c |=> (!rx_en && !tx_en && !clk_en && !irq && mask_q == 32'h0)); // R10
   AST_RX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_w && bus_wdata[CB_RX_OFF]) |=> !rx_en); // R2
   AST_TX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_w && bus_wdata[CB_TX_OFF]) |=> !tx_en); // R2
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovr_evt && !srst_c) |=> stat_vec[SB_RX_OVR]); // R3
   AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q & ~IRQ_SRC) == 32'h0); // R6
   AST_IDIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      idis_w |=> ((mask_q & $past(bus_wdata)) == 32'h0)); // R6
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == 32'h0) |-> !irq); // R7
   AST_RHR_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (rhr_r && !rx_push && !srst_c) |=> !stat_vec[SB_RX_RDY]); // R8
endmodule

bind aud_port_regs aud_port_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .rx_push   (rx_push),
   .rx_ovr_evt(rx_ovr_evt),
   .rx_en     (rx_en),
   .tx_en     (tx_en),
   .clk_en    (clk_en),
   .irq       (irq),
   .stat_vec  (status_w),
   .mask_q    (irq_mask)
);

// File: tb/aud_port_regs_tb.sv
`timescale 1ns/100ps
module aud_port_regs_tb;
   localparam int          NCH = 6;
   localparam logic [31:0] VER = 32'hA5C3_0204;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        rx_push = 0, rx_ovr_evt = 0, tx_pop = 0, tx_und_evt = 0;
   logic [31:0] rx_word = '0;
   logic [2:0]  rx_ovr_ch = '0, tx_und_ch = '0;
   logic [31:0] tx_word, mode_cfg;
   logic        rx_en, tx_en, clk_en, irq;

   always #2.5 clk = ~clk;

   aud_port_regs #(.NUM_CH(NCH), .ADDR_W(6), .VERSION_ID(VER)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_push(rx_push), .rx_word(rx_word), .rx_ovr_evt(rx_ovr_evt),
      .rx_ovr_ch(rx_ovr_ch), .tx_pop(tx_pop), .tx_und_evt(tx_und_evt),
      .tx_und_ch(tx_und_ch), .tx_word(tx_word), .mode_cfg(mode_cfg),
      .rx_en(rx_en), .tx_en(tx_en), .clk_en(clk_en), .irq(irq));

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   // model state
   logic        m_rx, m_ck, m_tx, m_rxrdy, m_full;
   logic [31:0] m_err, m_mask, m_mode, m_rxw, m_txw;

   function automatic logic [31:0] sticky_bits();
      logic [31:0] s = 32'h44;
      for (int c = 0; c < NCH; c++) begin
         s[8+c]  = 1'b1;
         s[20+c] = 1'b1;
      end
      return s;
   endfunction

   function automatic logic [31:0] stat_exp();
      logic [31:0] s = m_err;
      s[0] = m_rx; s[1] = m_rxrdy; s[4] = m_tx; s[5] = ~m_full;
      return s;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_rx = 0; m_ck = 0; m_tx = 0; m_rxrdy = 0; m_full = 0;
      m_err = '0; m_mask = '0; m_mode = '0; m_rxw = '0; m_txw = '0;
   endtask

   task automatic model_step(input logic wr, rd, input logic [5:0] a, input logic [31:0] d,
                             input logic rxp, input logic [31:0] rxd, input logic ovr,
                             input logic [2:0] oc, input logic ur, input logic [2:0] uc,
                             input logic pop);
      int w = int'(a[5:2]);
      if (wr && w == 0 && d[7]) begin
         model_reset();
         return;
      end
      if (wr && w == 0) begin
         if (d[1]) m_rx = 0; else if (d[0]) m_rx = 1;
         if (d[3]) m_ck = 0; else if (d[2]) m_ck = 1;
         if (d[5]) m_tx = 0; else if (d[4]) m_tx = 1;
      end
      if (wr && w == 3) m_err = m_err & ~d;
      if (wr && w == 4) m_err = m_err | (d & sticky_bits());
      if (ovr) begin m_err[2] = 1; if (oc < NCH) m_err[8+oc] = 1; end
      if (ur)  begin m_err[6] = 1; if (uc < NCH) m_err[20+uc] = 1; end
      if (wr && w == 5) m_mask = m_mask | (d & 32'h66);
      if (wr && w == 6) m_mask = m_mask & ~d;
      if (rxp) begin m_rxrdy = 1; m_rxw = rxd; end
      else if (rd && w == 8) m_rxrdy = 0;
      if (wr && w == 9) begin m_full = 1; m_txw = d; end
      else if (pop) m_full = 0;
      if (wr && w == 1) m_mode = d;
   endtask

   task automatic compare();
      bus_addr = 6'h08; #0.4;
      check("R3 status", bus_rdata, stat_exp());
      bus_addr = 6'h1C; #0.4;
      check("R6 mask", bus_rdata, m_mask);
      check("R2 enables", {29'd0, m_tx, m_ck, m_rx}, {29'd0, tx_en, clk_en, rx_en});
      check("R7 irq", {31'd0, irq}, {31'd0, |(stat_exp() & m_mask)});
      check("R9 tx_word", tx_word, m_txw);
      check("R11 mode_cfg", mode_cfg, m_mode);
   endtask

   task automatic step(input logic wr, rd, input logic [5:0] a, input logic [31:0] d,
                       input logic rxp, input logic [31:0] rxd, input logic ovr,
                       input logic [2:0] oc, input logic ur, input logic [2:0] uc,
                       input logic pop);
      @(negedge clk);
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      rx_push = rxp; rx_word = rxd; rx_ovr_evt = ovr; rx_ovr_ch = oc;
      tx_und_evt = ur; tx_und_ch = uc; tx_pop = pop;
      #0.5;
      if (rd && a[5:2] == 4'd8) check("R8 rhr data", bus_rdata, m_rxw);
      @(posedge clk);
      model_step(wr, rd, a, d, rxp, rxd, ovr, oc, ur, uc, pop);
      #0.5;
      bus_wr = 0; bus_rd = 0; rx_push = 0; rx_ovr_evt = 0; tx_und_evt = 0; tx_pop = 0;
      compare();
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      step(1, 0, a, d, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      bus_addr = 6'h08; #0.4; check("R1 status after reset", bus_rdata, 32'h20);
      bus_addr = 6'h1C; #0.4; check("R1 mask after reset", bus_rdata, 32'h0);
      check("R1 outputs after reset", {28'd0, rx_en, tx_en, clk_en, irq}, 32'h0);
      bus_addr = 6'h28; #0.4; check("R11 version", bus_rdata, VER);
      bus_addr = 6'h2C; #0.4; check("R11 unmapped reads 0", bus_rdata, 32'h0);
      // R2 commands and disable priority
      wr(6'h00, 32'h15);
      check("R2 all on", {29'd0, tx_en, clk_en, rx_en}, 32'h7);
      bus_addr = 6'h00; #0.4; check("R2 control reads 0", bus_rdata, 32'h0);
      wr(6'h00, 32'h03);
      check("R2 rx on+off -> off", {31'd0, rx_en}, 32'h0);
      wr(6'h00, 32'h3C);
      check("R2 tx/ck off wins", {30'd0, tx_en, clk_en}, 32'h0);
      // R3 out-of-range channel: summary only
      step(0, 0, 6'h3C, 0, 0, 0, 1, 3'd7, 1, 3'd6, 0);
      bus_addr = 6'h08; #0.4; check("R3 ch>=NUM_CH summary only", bus_rdata, 32'h64);
      step(0, 0, 6'h3C, 0, 0, 0, 1, 3'd5, 1, 3'd0, 0);
      bus_addr = 6'h08; #0.4; check("R3 per-channel bits", bus_rdata, 32'h0010_2064);
      // R4 clear vs same-cycle event
      step(1, 0, 6'h0C, 32'h0FF0_FF44, 0, 0, 1, 3'd1, 0, 0, 0);
      bus_addr = 6'h08; #0.4; check("R4 event beats clear", bus_rdata, 32'h0000_0224);
      wr(6'h0C, 32'hFFFF_FFFF);
      bus_addr = 6'h08; #0.4; check("R4 clear all", bus_rdata, 32'h20);
      // R5 set register
      wr(6'h10, 32'h0);
      bus_addr = 6'h08; #0.4; check("R5 set 0 no effect", bus_rdata, 32'h20);
      wr(6'h10, 32'hFFFF_FFFF);
      bus_addr = 6'h08; #0.4; check("R5 set forces sticky", bus_rdata, 32'h03F0_3F64);
      // R6/R7 mask and irq
      wr(6'h14, 32'hFFFF_FFFF);
      bus_addr = 6'h1C; #0.4; check("R6 mask only ready/error bits", bus_rdata, 32'h66);
      check("R7 irq high", {31'd0, irq}, 32'h1);
      wr(6'h0C, 32'hFFFF_FFFF);
      wr(6'h18, 32'h20);
      check("R7 irq low after masking ready", {31'd0, irq}, 32'h0);
      // R8 receive path
      step(0, 0, 6'h3C, 0, 1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
      check("R7 irq on rx ready", {31'd0, irq}, 32'h1);
      step(0, 1, 6'h20, 0, 1, 32'h1234_5678, 0, 0, 0, 0, 0);
      bus_addr = 6'h08; #0.4; check("R8 push+read keeps ready", bus_rdata[1], 1'b1);
      step(0, 1, 6'h20, 0, 0, 0, 0, 0, 0, 0, 0);
      bus_addr = 6'h08; #0.4; check("R8 read clears ready", {31'd0, bus_rdata[1]}, 32'h0);
      // R9 transmit path
      wr(6'h24, 32'hCAFE_0001);
      check("R9 tx word loaded", tx_word, 32'hCAFE_0001);
      step(1, 0, 6'h24, 32'hCAFE_0002, 0, 0, 0, 0, 0, 0, 1);
      bus_addr = 6'h08; #0.4; check("R9 write+pop stays full", {31'd0, bus_rdata[5]}, 32'h0);
      step(0, 0, 6'h3C, 0, 0, 0, 0, 0, 0, 0, 1);
      bus_addr = 6'h08; #0.4; check("R9 pop empties", {31'd0, bus_rdata[5]}, 32'h1);
      // R11 mode
      wr(6'h04, 32'h8123_4567);
      check("R11 mode written", mode_cfg, 32'h8123_4567);
      // R10 software reset with other bits and events
      wr(6'h00, 32'h15);
      wr(6'h14, 32'h66);
      step(1, 0, 6'h00, 32'h95, 1, 32'h1, 1, 3'd2, 1, 3'd3, 0);
      bus_addr = 6'h08; #0.4; check("R10 status after sw reset", bus_rdata, 32'h20);
      check("R10 outputs after sw reset", {28'd0, rx_en, tx_en, clk_en, irq}, 32'h0);
      check("R10 mode after sw reset", mode_cfg, 32'h0);
      // random phase
      for (int i = 0; i < 1500; i++) begin
         logic [5:0]  a;
         logic [31:0] d;
         logic        w, r;
         int          sel = $urandom_range(0, 11);
         a = (sel == 11) ? 6'h30 : 6'(sel * 4);
         d = $urandom;
         if (sel == 0 && ($urandom_range(0, 39) != 0)) d[7] = 1'b0;
         if (sel == 3 && ($urandom_range(0, 2) != 0)) d = d & 32'h00F0_0F00;
         w = ($urandom_range(0, 3) != 0) && (sel != 8);
         r = (sel == 8) && ($urandom_range(0, 1) == 1);
         step(w, r, a, d, ($urandom_range(0, 3) == 0), $urandom,
              ($urandom_range(0, 5) == 0), 3'($urandom_range(0, 7)),
              ($urandom_range(0, 5) == 0), 3'($urandom_range(0, 7)),
              ($urandom_range(0, 3) == 0));
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule